// File: doc/BRIEF.md
# Event Timestamp Capture Timer

This block is a free-running up-counter that stamps incoming events with the time they arrive. While the timer runs, the counter steps from zero to all-ones and wraps back to zero without pausing. A selected edge on the single event input copies the current count into a capture register. The same capture sets a capture flag and emits a one-cycle event pulse.

Each wrap of the counter sets an overflow flag. Software counts these wraps to extend the measured interval between two captures. Each flag has its own interrupt enable. The event input passes through a two-stage synchronizer. An optional noise filter can follow it, and that filter rejects input levels shorter than four clock samples.

Software programs the block with one 8-bit control byte. The byte is written with a write strobe and can be read back. Each flag is cleared with its own strobe. The counter value and the capture register are always visible on output ports, with no handshake on either.

Top module: `evcap_timer`

## Requirements
- R1: While the run bit (control bit 0) is 1, the counter adds one on every prescaler tick and wraps from 16'hFFFF to 0. While the run bit is 0, the counter holds its value. A capture never changes the counter.
- R2: The prescale field (control bits 2:1) sets how often the counter advances. The values 0, 1, 2 and 3 mean once every 1, 2, 4 and 8 clocks. The divider restarts from zero whenever the run bit is 0.
- R3: On a qualified edge, the capture register takes the counter value held at the clock edge where the capture happens. With the filter off, that capture edge is the third rising clock edge after the input changes: two synchronizer stages, then the edge decision.
- R4: Each capture sets the capture flag. It also drives the event output high for exactly one cycle, starting in the same cycle that the new capture value appears.
- R5: The edge-select bit (control bit 4) chooses the active edge: 0 captures on a rising input, 1 captures on a falling input. The other edge has no effect.
- R6: Events are ignored while the capture-enable bit (control bit 3) is 0, and also while the run bit is 0. In that case the capture register, the capture flag and the event output stay unchanged.
- R7: The clock edge on which the counter wraps from 16'hFFFF to 0 also sets the overflow flag.
- R8: The capture interrupt (enable at control bit 6) equals the capture flag AND its enable. The overflow interrupt (enable at control bit 7) equals the overflow flag AND its enable.
- R9: With the filter bit (control bit 5) set, a new input level is accepted only after four consecutive samples that differ from the accepted level. Shorter pulses are dropped, and captures come four cycles later than with the filter off.
- R10: A clear strobe clears its flag on the next clock edge. If the flag is set and cleared on the same edge, the set wins.
- R11: After reset, the counter, the capture register, both flags, both interrupts, the event output and the control byte are all zero. The control byte written reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte to write |
| ctrl_rdata | output | 8 | Current control byte |
| evt_in | input | 1 | Asynchronous event input |
| clr_capt | input | 1 | Capture flag clear strobe |
| clr_ovf | input | 1 | Overflow flag clear strobe |
| cnt_o | output | 16 | Current counter value |
| capt_o | output | 16 | Capture register |
| capt_flag | output | 1 | Capture flag |
| ovf_flag | output | 1 | Overflow flag |
| capt_irq | output | 1 | Capture interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| evt_out | output | 1 | One-cycle pulse per capture |

## Verification
A wrong counter or prescaler state appears on cnt_o one cycle later. Because every capture copies the counter, the same fault also appears in the next captured value. A fault in the synchronizer, filter or edge detector moves the capture by whole cycles. That shows up as a captured value that is off by the same number of counts, or as an event pulse that is missing or extra. A fault in the flag logic shows on the flag and interrupt pins at the very next edge. The set-versus-clear cases are driven on purpose at a capture and at the counter wrap.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  localparam int CTRL_W  = 8;
  localparam int PRESC_W = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // Field order is MSB first; the control byte layout is software visible.
  typedef struct packed {
    logic               ovf_ie;
    logic               capt_ie;
    logic               filt_en;
    edge_sel_e          edge_sel;
    logic               capt_en;
    logic [PRESC_W-1:0] presc;
    logic               run;
  } ctrl_t;
endpackage

// File: rtl/evcap_prescaler.sv
module evcap_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   mask_w;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask_w = ({{PRE_W{1'b0}}, 1'b1} << sel) - 1'b1;
    mask   = mask_w[PRE_W-1:0];
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
    else          pre_q <= '0;
  end
endmodule

// File: rtl/evcap_counter.sv
module evcap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/evcap_input_cond.sv
module evcap_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  input  logic filt_en,
  input  logic edge_fall,
  output logic hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic                   filt_lvl;
  logic                   cond;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};
  end
  assign samp = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_filt
      localparam int FCNT_W = $clog2(FILT_LEN);
      logic [FCNT_W-1:0] run_q;
      logic              lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= '0;
          lvl_q <= 1'b0;
        end else if (samp == lvl_q) begin
          run_q <= '0;
        end else if (run_q == FCNT_W'(FILT_LEN - 1)) begin
          run_q <= '0;
          lvl_q <= samp;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
      assign filt_lvl = lvl_q;
    end else begin : g_nofilt
      assign filt_lvl = samp;
    end
  endgenerate

  assign cond = filt_en ? filt_lvl : samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  assign hit = edge_fall ? (prev_q && !cond) : (cond && !prev_q);
endmodule

// File: rtl/evcap_timer.sv
module evcap_timer
  import evcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              evt_in,
  input  logic              clr_capt,
  input  logic              clr_ovf,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  capt_o,
  output logic              capt_flag,
  output logic              ovf_flag,
  output logic              capt_irq,
  output logic              ovf_irq,
  output logic              evt_out
);
  ctrl_t ctrl_q;
  logic  run;
  logic  capt_en;
  logic  tick;
  logic  wrap;
  logic  hit;
  logic  cap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
  end
  assign ctrl_rdata = ctrl_q;
  assign run        = ctrl_q.run;
  assign capt_en    = ctrl_q.capt_en;

  evcap_prescaler #(.SEL_W(PRESC_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (ctrl_q.presc),
    .tick  (tick)
  );

  evcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt   (cnt_o),
    .wrap  (wrap)
  );

  evcap_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .filt_en   (ctrl_q.filt_en),
    .edge_fall (ctrl_q.edge_sel == EDGE_FALL),
    .hit       (hit)
  );

  assign cap_now = run && capt_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_o    <= '0;
      capt_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      evt_out   <= 1'b0;
    end else begin
      evt_out <= cap_now;
      if (cap_now) capt_o <= cnt_o;
      // set takes priority over clear
      if (cap_now)       capt_flag <= 1'b1;
      else if (clr_capt) capt_flag <= 1'b0;
      if (wrap)          ovf_flag  <= 1'b1;
      else if (clr_ovf)  ovf_flag  <= 1'b0;
    end
  end

  assign capt_irq = capt_flag && ctrl_q.capt_ie;
  assign ovf_irq  = ovf_flag && ctrl_q.ovf_ie;
endmodule

// File: rtl/evcap_timer_chk.sv
module evcap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             capt_en,
  input logic             tick,
  input logic             cap_now,
  input logic             clr_capt,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] capt_o,
  input logic             capt_flag,
  input logic             ovf_flag,
  input logic             capt_irq,
  input logic             ovf_irq,
  input logic             evt_out
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(&cnt_o)) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_o));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_o)) |=> (ovf_flag && cnt_o == '0));

  // R3
  capt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> (capt_o == $past(cnt_o)));

  // R4
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |=> !evt_out);

  // R4
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> capt_flag);

  // R6
  capt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !capt_en) |=> (!evt_out && $stable(capt_o)));

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capt_irq |-> capt_flag) and (ovf_irq |-> ovf_flag));

  // R10
  clr_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_capt && !cap_now) |=> !capt_flag);
endmodule

bind evcap_timer evcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .capt_en   (capt_en),
  .tick      (tick),
  .cap_now   (cap_now),
  .clr_capt  (clr_capt),
  .cnt_o     (cnt_o),
  .capt_o    (capt_o),
  .capt_flag (capt_flag),
  .ovf_flag  (ovf_flag),
  .capt_irq  (capt_irq),
  .ovf_irq   (ovf_irq),
  .evt_out   (evt_out)
);

// File: tb/evcap_timer_bench.sv
`timescale 1ns/1ps
module evcap_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata;
  logic        evt_in = 1'b0;
  logic        clr_capt = 1'b0;
  logic        clr_ovf = 1'b0;
  logic [15:0] cnt_o, capt_o;
  logic        capt_flag, ovf_flag, capt_irq, ovf_irq, evt_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evcap_timer u_evcap_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .evt_in(evt_in), .clr_capt(clr_capt),
    .clr_ovf(clr_ovf), .cnt_o(cnt_o), .capt_o(capt_o), .capt_flag(capt_flag),
    .ovf_flag(ovf_flag), .capt_irq(capt_irq), .ovf_irq(ovf_irq), .evt_out(evt_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference state
  bit   m_s1, m_s2, m_filt, m_prev, m_cf, m_of, m_evo;
  int   m_run_len, m_cnt, m_capt, m_pre;
  logic [7:0] m_ctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_cf = 0; m_of = 0; m_evo = 0;
      m_run_len = 0; m_cnt = 0; m_capt = 0; m_pre = 0; m_ctrl = '0;
    end else begin
      bit run, cen, lvl, e, cap, tk, wr;
      int mask;
      run  = m_ctrl[0];
      cen  = m_ctrl[3];
      mask = (1 << m_ctrl[2:1]) - 1;
      lvl  = m_ctrl[5] ? m_filt : m_s2;
      e    = m_ctrl[4] ? (m_prev && !lvl) : (lvl && !m_prev);
      cap  = run && cen && e;
      tk   = run && ((m_pre & mask) == mask);
      wr   = tk && (m_cnt == 65535);
      m_evo = cap;
      if (cap) m_capt = m_cnt;
      m_cf = cap ? 1'b1 : (clr_capt ? 1'b0 : m_cf);
      m_of = wr  ? 1'b1 : (clr_ovf  ? 1'b0 : m_of);
      if (tk) m_cnt = (m_cnt + 1) % 65536;
      m_pre = run ? (m_pre + 1) % 8 : 0;
      m_prev = lvl;
      if (m_s2 == m_filt) m_run_len = 0;
      else if (m_run_len == 3) begin m_run_len = 0; m_filt = m_s2; end
      else m_run_len++;
      m_s2 = m_s1;
      m_s1 = evt_in;
      if (ctrl_we) m_ctrl = ctrl_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 cnt_o", cnt_o, m_cnt);
      chk("R3 capt_o", capt_o, m_capt);
      chk("R4 capt_flag", capt_flag, m_cf);
      chk("R4 evt_out", evt_out, m_evo);
      chk("R7 ovf_flag", ovf_flag, m_of);
      chk("R8 capt_irq", capt_irq, m_cf && m_ctrl[6]);
      chk("R8 ovf_irq", ovf_irq, m_of && m_ctrl[7]);
      chk("R11 ctrl_rdata", ctrl_rdata, m_ctrl);
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    evt_in = ~evt_in;
    repeat (hi) @(negedge clk);
    evt_in = ~evt_in;
    repeat (lo) @(negedge clk);
  endtask

  task automatic clear_capt();
    clr_capt = 1'b1;
    @(negedge clk);
    clr_capt = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset cnt", cnt_o, 0);
    chk("R11 reset capt", capt_o, 0);
    chk("R11 reset flags", {capt_flag, ovf_flag, capt_irq, ovf_irq, evt_out}, 0);
    chk("R11 reset ctrl", ctrl_rdata, 0);

    // R1 R3 R4: rising edge, no filter, divide by 1
    wr_ctrl(8'h49);
    repeat (10) @(negedge clk);
    c0 = cnt_o;
    evt_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 capture latency value", capt_o, c0 + 16'd2);
    chk("R4 event pulse", evt_out, 1);
    @(negedge clk);
    chk("R4 event pulse width", evt_out, 0);
    chk("R1 counter not stopped", cnt_o, c0 + 16'd4);
    evt_in = 1'b0;
    repeat (4) @(negedge clk);
    pulse(2, 5); pulse(1, 3); pulse(6, 6);
    clear_capt();
    @(negedge clk);
    chk("R10 flag cleared", capt_flag, 0);

    // R5 falling edge select
    wr_ctrl(8'h59);
    pulse(4, 6); pulse(1, 4);

    // R6 capture disabled, then timer stopped
    clear_capt();
    wr_ctrl(8'h41);
    pulse(3, 6); pulse(2, 6);
    chk("R6 ignored with capture off", {evt_out, capt_flag}, 0);
    wr_ctrl(8'h48);
    pulse(3, 6); pulse(5, 6);
    chk("R6 ignored with timer stopped", {evt_out, capt_flag}, 0);

    // R9 filter: short glitches dropped, long pulse accepted 4 cycles late
    wr_ctrl(8'h69);
    repeat (6) @(negedge clk);
    pulse(1, 6); pulse(2, 6); pulse(3, 8);
    chk("R9 short pulses dropped", capt_flag, 0);
    c0 = cnt_o;
    evt_in = 1'b1;
    repeat (7) @(negedge clk);
    chk("R9 filtered capture value", capt_o, c0 + 16'd6);
    chk("R9 filtered event", evt_out, 1);
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    repeat (8) @(negedge clk);

    // R2 prescale settings
    for (int p = 1; p < 4; p++) begin
      wr_ctrl(8'h49 | 8'(p << 1));
      repeat (5) @(negedge clk);
      pulse(3, 11); pulse(7, 13);
    end
    wr_ctrl(8'h48);
    wr_ctrl(8'h4D);
    repeat (20) @(negedge clk);

    // R10 set wins over clear at a capture
    wr_ctrl(8'h49);
    repeat (4) @(negedge clk);
    clear_capt();
    evt_in = 1'b1;
    clr_capt = 1'b1;
    repeat (3) @(negedge clk);
    clr_capt = 1'b0;
    chk("R10 capture set beats clear", capt_flag, 1);
    evt_in = 1'b0;
    repeat (4) @(negedge clk);

    // R7 R10 overflow with clear on the wrap edge
    wr_ctrl(8'hC9);
    while (cnt_o != 16'hFFFE) @(negedge clk);
    clr_ovf = 1'b1;
    repeat (2) @(negedge clk);
    clr_ovf = 1'b0;
    chk("R7 wrap to zero", cnt_o, 0);
    chk("R10 overflow set beats clear", ovf_flag, 1);
    chk("R8 overflow irq", ovf_irq, 1);
    clr_ovf = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0;
    chk("R10 overflow cleared", ovf_flag, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule